// File: doc/BRIEF.md
# Serial Motor-Setting Register

This block is the configuration port for one channel of a brushed DC motor chopper controller. A host shifts a 16-bit setting word in over three wires: a data line, a serial clock and a load strobe. The block samples the data line on each rising serial clock edge. The first bit sent ends up in bit 0 of the word. A capture register then holds the word and splits it into the fields that the analog and chopping logic need: a blanking-time code, a torque range, a decay mode, a 5-bit current level and a direction bit.

The capture register has two behaviours, selected by the strobe level. While the strobe is low, the capture register tracks the shift register. While the strobe is high, the capture register holds its value. It takes a new word only on the strobe's rising edge.

A control-select input chooses between serial control and PWM control. Under PWM control, only the low seven bits (blanking, torque and decay) take effect. The current level is then forced to full scale, and the direction comes from an external phase pin. All serial and control inputs are asynchronous. They pass through a synchronizer before any logic uses them. A synchronous reset returns the shift and capture registers to a fixed default word.

Top module: `mdrv_setreg`

## Requirements
- R1: One cycle after reset, both the shift register and the capture register hold the default word 0x0FA7. With serial control selected, this word decodes to blanking 7, torque 00 (25 %), decay 01, current 31 and direction 0.
- R2: Each rising edge of `ser_clk` shifts `ser_data` in at bit 15 and moves every bit down one place. After 16 edges, the first bit sent is bit 0.
- R3: The word decodes by bit position: bits 2..0 give the blanking code, bits 4..3 the torque code, bits 6..5 the decay code, bits 11..7 the current level and bit 12 the direction. Bits 15..13 affect no output.
- R4: `torque_pct` reports 25, 50, 75 or 100 for torque codes 00, 01, 10 and 11.
- R5: `decay_code` shows bits 6..5 unchanged: 00 slow, 01 mixed 37.5 %, 10 mixed 75 %, 11 fast. `dir_positive` is 1 for positive direction and 0 for negative.
- R6: While `ser_latch` stays high, shifting does not change any output. A low-to-high transition of `ser_latch` makes the shifted word visible.
- R7: While `ser_latch` is low, the outputs follow the shift register contents, including partly shifted words.
- R8: With `ctl_serial` low (PWM control), `current_code` is 31 and `dir_positive` equals `phase_pin`. Blanking, torque and decay still come from the captured word. Setting `ctl_serial` high again shows the captured current and direction without a new strobe.
- R9: A reset asserted in the middle of a shift sequence discards the partly shifted bits. The shift register and the capture register both return to the default word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (sleep or fault) |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_data | input | 1 | Serial data, bit 0 first |
| ser_latch | input | 1 | Capture strobe: low = transparent, rising edge = load |
| ctl_serial | input | 1 | 1 = serial control, 0 = PWM control |
| phase_pin | input | 1 | External direction used under PWM control |
| blank_code | output | 3 | Blanking-time code |
| torque_code | output | 2 | Torque range code |
| torque_pct | output | 7 | Torque range in percent |
| decay_code | output | 2 | Decay mode code |
| current_code | output | 5 | Current level after mode masking |
| dir_positive | output | 1 | Direction after mode masking, 1 = positive |

## Verification
The bench sweeps all 128 values of the low seven bits in serial mode. Each word also carries a varying current level, direction bit and junk in bits 15..13. This separates a wrong bit order or field offset from a wrong torque scale, and it shows that the upper bits are ignored. Every word is shifted in with the strobe held high and checked before and after the strobe edge, so a capture that leaks mid-shift stands apart from a capture that never happens. A transparent run checks half-shifted contents. A PWM sweep toggles the phase pin against varied stored current and direction bits. A reset in the middle of a shift checks that the shift register was cleared, and does not only check the capture register.

// File: rtl/mdrv_cfg_pkg.sv
package mdrv_cfg_pkg;

    // Word geometry and field placement (positions are decoded downstream)
    localparam int WORD_W    = 16;
    localparam int BLANK_LSB = 0;
    localparam int BLANK_W   = 3;
    localparam int TORQ_LSB  = 3;
    localparam int TORQ_W    = 2;
    localparam int DECAY_LSB = 5;
    localparam int DECAY_W   = 2;
    localparam int LEVEL_LSB = 7;
    localparam int LEVEL_W   = 5;
    localparam int DIR_BIT   = 12;
    localparam int USED_W    = DIR_BIT + 1;
    localparam int PCT_W     = 7;
    localparam int PCT_STEP  = 25;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [USED_W-1:0] used_t;

    typedef enum logic [1:0] {
        TQ_25  = 2'b00,
        TQ_50  = 2'b01,
        TQ_75  = 2'b10,
        TQ_100 = 2'b11
    } torque_e;

    typedef enum logic [1:0] {
        DK_SLOW   = 2'b00,
        DK_MIX_LO = 2'b01,
        DK_MIX_HI = 2'b10,
        DK_FAST   = 2'b11
    } decay_e;

    typedef struct packed {
        logic [BLANK_W-1:0] blank;
        torque_e            torque;
        decay_e             decay;
        logic [LEVEL_W-1:0] level;
        logic               dir;
    } setting_t;

    localparam logic [BLANK_W-1:0] BLANK_INIT = '1;
    localparam logic [LEVEL_W-1:0] LEVEL_FULL = '1;

    localparam word_t DEFAULT_WORD =
          (word_t'(BLANK_INIT) << BLANK_LSB)
        | (word_t'(TQ_25)      << TORQ_LSB)
        | (word_t'(DK_MIX_LO)  << DECAY_LSB)
        | (word_t'(LEVEL_FULL) << LEVEL_LSB);

    function automatic setting_t unpack_word(used_t w);
        setting_t s;
        s.blank  = w[BLANK_LSB +: BLANK_W];
        s.torque = torque_e'(w[TORQ_LSB +: TORQ_W]);
        s.decay  = decay_e'(w[DECAY_LSB +: DECAY_W]);
        s.level  = w[LEVEL_LSB +: LEVEL_W];
        s.dir    = w[DIR_BIT];
        return s;
    endfunction

    function automatic logic [PCT_W-1:0] torque_percent(torque_e t);
        return PCT_W'(PCT_STEP * (int'(t) + 1));
    endfunction

    localparam setting_t DEFAULT_SET = unpack_word(DEFAULT_WORD[USED_W-1:0]);

endpackage

// File: rtl/mdrv_in_sync.sv
module mdrv_in_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdrv_rise_det.sv
module mdrv_rise_det #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/mdrv_shift.sv
module mdrv_shift
    import mdrv_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  bit_in,
    output word_t sr
);
    // Insert at the top so the first bit sent lands in bit 0 after a full word
    always_ff @(posedge clk) begin
        if (rst)       sr <= DEFAULT_WORD;
        else if (step) sr <= {bit_in, sr[WORD_W-1:1]};
    end
endmodule

// File: rtl/mdrv_capture.sv
module mdrv_capture
    import mdrv_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  word_t    sr,
    input  logic     lat_lvl,
    input  logic     lat_rise,
    output setting_t cap
);
    logic load;

    // Transparent while the strobe is low, one more load on its rising edge
    assign load = !lat_lvl || lat_rise;

    always_ff @(posedge clk) begin
        if (rst)       cap <= DEFAULT_SET;
        else if (load) cap <= unpack_word(sr[USED_W-1:0]);
    end
endmodule

// File: rtl/mdrv_field_out.sv
module mdrv_field_out
    import mdrv_cfg_pkg::*;
(
    input  setting_t           cap,
    input  logic               serial_mode,
    input  logic               phase_lvl,
    output logic [BLANK_W-1:0] blank_code,
    output logic [TORQ_W-1:0]  torque_code,
    output logic [PCT_W-1:0]   torque_pct,
    output logic [DECAY_W-1:0] decay_code,
    output logic [LEVEL_W-1:0] current_code,
    output logic               dir_positive
);
    always_comb begin
        blank_code   = cap.blank;
        torque_code  = cap.torque;
        torque_pct   = torque_percent(cap.torque);
        decay_code   = cap.decay;
        current_code = serial_mode ? cap.level : LEVEL_FULL;
        dir_positive = serial_mode ? cap.dir   : phase_lvl;
    end
endmodule

// File: rtl/mdrv_setreg.sv
module mdrv_setreg
    import mdrv_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_latch,
    input  logic       ctl_serial,
    input  logic       phase_pin,
    output logic [2:0] blank_code,
    output logic [1:0] torque_code,
    output logic [6:0] torque_pct,
    output logic [1:0] decay_code,
    output logic [4:0] current_code,
    output logic       dir_positive
);
    localparam int N_IN   = 5;
    localparam int N_EDGE = 2;

    logic [N_IN-1:0]   raw_in;
    logic [N_IN-1:0]   sync_in;
    logic [N_EDGE-1:0] edge_lvl;
    logic [N_EDGE-1:0] edge_rise;

    logic     clk_s, data_s, lat_s, mode_s, phase_s;
    logic     clk_rise, lat_rise;
    word_t    sr;
    setting_t cap;

    assign raw_in = {ser_clk, ser_data, ser_latch, ctl_serial, phase_pin};
    assign {clk_s, data_s, lat_s, mode_s, phase_s} = sync_in;

    mdrv_in_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    assign edge_lvl = {clk_s, lat_s};
    assign {clk_rise, lat_rise} = edge_rise;

    mdrv_rise_det #(.WIDTH(N_EDGE)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  (edge_lvl),
        .rise (edge_rise)
    );

    mdrv_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .step   (clk_rise),
        .bit_in (data_s),
        .sr     (sr)
    );

    mdrv_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .sr       (sr),
        .lat_lvl  (lat_s),
        .lat_rise (lat_rise),
        .cap      (cap)
    );

    mdrv_field_out u_out (
        .cap          (cap),
        .serial_mode  (mode_s),
        .phase_lvl    (phase_s),
        .blank_code   (blank_code),
        .torque_code  (torque_code),
        .torque_pct   (torque_pct),
        .decay_code   (decay_code),
        .current_code (current_code),
        .dir_positive (dir_positive)
    );
endmodule

// File: rtl/mdrv_setreg_chk.sv
module mdrv_setreg_chk
    import mdrv_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       step,
    input logic       data_s,
    input logic       lat_s,
    input logic       lat_rise,
    input logic       mode_s,
    input logic       phase_s,
    input word_t      sr,
    input setting_t   cap,
    input logic [4:0] current_code,
    input logic       dir_positive
);
    logic rst_q = 1'b0;

    always_ff @(posedge clk) rst_q <= rst;

    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (sr == DEFAULT_WORD && cap == DEFAULT_SET));

    assert_shift_order_R2: assert property (@(posedge clk) disable iff (rst)
        step |=> (sr == {$past(data_s), $past(sr[WORD_W-1:1])}));

    assert_latched_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (lat_s && $past(lat_s) && !$past(rst)) |=> $stable(cap));

    assert_strobe_load_R6: assert property (@(posedge clk) disable iff (rst)
        lat_rise |=> (cap == unpack_word($past(sr[USED_W-1:0]))));

    assert_transparent_R7: assert property (@(posedge clk) disable iff (rst)
        !lat_s |=> (cap == unpack_word($past(sr[USED_W-1:0]))));

    assert_pwm_current_R8: assert property (@(posedge clk) disable iff (rst)
        !mode_s |-> (current_code == LEVEL_FULL));

    assert_pwm_phase_R8: assert property (@(posedge clk) disable iff (rst)
        !mode_s |-> (dir_positive == phase_s));
endmodule

bind mdrv_setreg mdrv_setreg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .step         (clk_rise),
    .data_s       (data_s),
    .lat_s        (lat_s),
    .lat_rise     (lat_rise),
    .mode_s       (mode_s),
    .phase_s      (phase_s),
    .sr           (sr),
    .cap          (cap),
    .current_code (current_code),
    .dir_positive (dir_positive)
);

// File: tb/mdrv_setreg_test.sv
`timescale 1ns/1ps
module mdrv_setreg_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b1;
    logic ctl_serial = 1'b1, phase_pin = 1'b0;
    logic [2:0] blank_code;
    logic [1:0] torque_code;
    logic [6:0] torque_pct;
    logic [1:0] decay_code;
    logic [4:0] current_code;
    logic       dir_positive;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] m_sr;
    logic [15:0] m_cap;
    localparam logic [15:0] DEF = 16'h0FA7;

    always #2.5 clk = ~clk;

    mdrv_setreg uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .ctl_serial(ctl_serial), .phase_pin(phase_pin),
        .blank_code(blank_code), .torque_code(torque_code), .torque_pct(torque_pct),
        .decay_code(decay_code), .current_code(current_code), .dir_positive(dir_positive)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [19:0] expect_out(logic [15:0] w, logic mode, logic ph);
        logic [4:0] lvl;
        logic       d;
        logic [6:0] pct;
        lvl = mode ? w[11:7] : 5'h1F;
        d   = mode ? w[12] : ph;
        pct = 7'((int'(w[4:3]) + 1) * 25);
        return {w[2:0], w[4:3], pct, w[6:5], lvl, d};
    endfunction

    task automatic check_word(input string req, input logic [15:0] w);
        logic [19:0] act, exp;
        act = {blank_code, torque_code, torque_pct, decay_code, current_code, dir_positive};
        exp = expect_out(w, ctl_serial, phase_pin);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s word %h: actual %h expected %h", req, w, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = w[i];
            tick(3);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            m_sr = {w[i], m_sr[15:1]};
            if (!ser_latch) m_cap = m_sr;
        end
        tick(6);
    endtask

    task automatic strobe;
        ser_latch = 1'b0;
        tick(3);
        ser_latch = 1'b1;
        tick(6);
        m_cap = m_sr;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [15:0] w;
        logic [15:0] w2;
        tick(4);
        rst = 1'b0;
        m_sr = DEF;
        m_cap = DEF;
        tick(5);
        // R1 defaults
        check_word("R1", DEF);

        // R2 R3 R4 R5 R6: full sweep of low seven bits, latched capture
        for (int v = 0; v < 128; v++) begin
            w = {3'(v * 5), 1'(v ^ (v >> 3)), 5'(v * 7 + 3), 7'(v)};
            shift_bits(w, 16);
            check_word("R6 hold", m_cap);
            strobe();
            check_word("R2/R3/R4/R5", w);
        end

        // R7 transparent tracking
        ser_latch = 1'b0;
        tick(6);
        w = 16'hB5C3;
        shift_bits(w, 16);
        check_word("R7 full", w);
        w2 = 16'h4E19;
        shift_bits(w2, 8);
        check_word("R7 partial", m_sr);
        ser_latch = 1'b1;
        tick(6);

        // R8 PWM control masks current and direction
        ctl_serial = 1'b0;
        tick(6);
        for (int v = 0; v < 32; v++) begin
            w = {3'b101, 1'(v), 5'(v * 3 + 1), 7'(v * 4 + 1)};
            shift_bits(w, 16);
            strobe();
            for (int p = 0; p < 2; p++) begin
                phase_pin = 1'(p);
                tick(5);
                check_word("R8 pwm", w);
            end
        end
        ctl_serial = 1'b1;
        tick(5);
        check_word("R8 restore", w);

        // R9 reset in the middle of a shift
        w = 16'h7A5E;
        shift_bits(w, 8);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        m_sr = DEF;
        m_cap = DEF;
        tick(5);
        check_word("R9 capture", DEF);
        ser_latch = 1'b0;
        tick(6);
        check_word("R9 shift", DEF);
        shift_bits(w, 5);
        check_word("R9 reshift", m_sr);
        ser_latch = 1'b1;
        tick(6);

        finish_run();
    end
endmodule